// File: doc/BRIEF.md
# Bus Master Transaction Sequencer for a 32-bit Parallel Bus

This block is the initiator side of a 32-bit multiplexed address/data bus with the conventional PCI handshake. A local client presents a transaction: an address, a four-bit bus command, active-low byte enables and a burst length. The sequencer then runs the whole bus exchange. It requests the bus and waits for the grant. It drives the address phase and moves one or more data phases with the initiator-ready and target-ready handshake. It then releases every shared line for one turnaround cycle.

During writes, the block publishes the index of the word it needs next, and the client answers with that word on `wdata`. During reads, each captured word comes back with a one-cycle valid strobe. When the transaction ends, a one-cycle done strobe carries a status code and the number of data phases that completed.

A transaction can end in three ways. It ends normally after the last data phase. It ends as a retry when the target signals stop without target-ready. It ends as a master abort when no target claims the cycle within a fixed window. A master abort also raises a sticky flag that stays set until the client pulses a clear input. Every shared bus line is modelled as a value plus an output enable, so the tri-state buffers stay outside the block.

Top module: `pci_mst_seq`

## Requirements
- R1: A `start` pulse is taken only while `idle` is high. `req_n` goes low on the next edge. The block then samples `gnt_n` on each following edge. On the edge after `gnt_n` is sampled low, it drives `frame_n_o` low, `ad_o` with the address and `cbe_n_o` with the command, all with their enables high. On that same edge it releases `req_n`. The address phase lasts exactly one cycle.
- R2: In the cycle after the address phase, `irdy_n_o` is low and `cbe_n_o` carries the byte enables. For a write (command bit 0 = 1), `ad_o` carries word 0 with `ad_oe` high. For a read (command bit 0 = 0), `ad_oe` stays low for every data phase.
- R3: A data phase completes only on an edge where `irdy_n_o` and `trdy_n` are both low. For a read, `rd_data` holds the sampled `ad_i` and `rd_valid` is high in the following cycle. For a write, word k+1 (selected by `wr_idx`) appears on `ad_o` after word k completes.
- R4: `frame_n_o` goes high at the start of the final data phase while `irdy_n_o` stays low. A length of 0 is treated as 1.
- R5: After a normal end, all output enables are low for one cycle, with `done` high, status 0 (OK) and `beat_count` equal to the length. `idle` is high in the cycle after that.
- R6: `devsel_n` is sampled on the edges of the data state. If it is high on the first 8 of them, the transaction ends with status 2 (master abort) and `beat_count` 0. A target that claims on the 8th sample completes normally.
- R7: `stop_n` low with `trdy_n` high ends the transaction with status 1 (retry). `beat_count` then equals the number of phases completed before the stop, and the stopped phase is not counted.
- R8: When an early termination (retry or abort) occurs while `frame_n_o` is low, `frame_n_o` rises first with `irdy_n_o` still low. All lines float on the following edge.
- R9: `mabort_flag` is set when a master abort ends and stays set until a `mabort_clr` pulse clears it on the next edge.
- R10: Target wait states (`trdy_n` high, `stop_n` high) hold the current write word and do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| start_addr | input | 32 | Transaction address |
| start_cmd | input | 4 | Bus command, bit 0 = 1 for write |
| start_be_n | input | 4 | Active-low byte enables for all data phases |
| start_len | input | 4 | Number of data phases (0 treated as 1) |
| wdata | input | 32 | Write word selected by `wr_idx` |
| wr_idx | output | 4 | Index of the write word needed next |
| idle | output | 1 | Sequencer ready for a new transaction |
| rd_data | output | 32 | Captured read word |
| rd_valid | output | 1 | `rd_data` valid strobe |
| done | output | 1 | Transaction finished strobe |
| done_status | output | 2 | 0 OK, 1 retry, 2 master abort |
| beat_count | output | 4 | Completed data phases, valid with `done` |
| mabort_flag | output | 1 | Sticky master abort flag |
| mabort_clr | input | 1 | Clear pulse for `mabort_flag` |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n_o | output | 1 | FRAME# value |
| frame_oe | output | 1 | FRAME# drive enable |
| irdy_n_o | output | 1 | IRDY# value |
| irdy_oe | output | 1 | IRDY# drive enable |
| ad_o | output | 32 | Address/data value driven |
| ad_oe | output | 1 | Address/data drive enable |
| cbe_n_o | output | 4 | Command/byte-enable value |
| cbe_oe | output | 1 | Command/byte-enable drive enable |
| ad_i | input | 32 | Address/data value sampled |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| stop_n | input | 1 | Target stop, active low |

## Verification
The bench delays the grant by two cycles and checks the exact cycles in which FRAME#, the address and IRDY# appear. A launch rule that is off by one would drive the address while the grant is still unsampled, or would leave an idle gap. The claim window is tested on both sides of its edge: a claim on the eighth sample must succeed, and no claim at all must abort. A counter that is off by one flips one of these two outcomes. A retry in the middle of a burst checks that the stopped phase is not counted and that FRAME# is dropped before IRDY#. Alternating wait states check that write words are held and that read words are taken only on true handshakes; a design that advanced on TRDY# alone would skip or repeat words.

// File: rtl/pci_mst_pkg.sv
package pci_mst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_ADDR, ST_DATA, ST_DRAIN, ST_TURN
  } mst_state_e;

  typedef enum logic [1:0] {
    STAT_OK     = 2'd0,
    STAT_RETRY  = 2'd1,
    STAT_MABORT = 2'd2
  } mst_status_e;

  function automatic logic cmd_is_write(input logic [3:0] cmd);
    return cmd[0];
  endfunction
endpackage

// File: rtl/pci_mst_dsel_timer.sv
// Counts data-state samples with DEVSEL# high until a claim is seen.
module pci_mst_dsel_timer #(
  parameter int TMO = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic devsel_n,
  output logic expired
);
  localparam int CW = $clog2(TMO + 1);

  logic [CW-1:0] miss_cnt;
  logic          claimed;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      miss_cnt <= '0;
      claimed  <= 1'b0;
    end else if (!devsel_n) begin
      claimed  <= 1'b1;
    end else if (!claimed) begin
      miss_cnt <= miss_cnt + 1'b1;
    end
  end

  assign expired = run && !claimed && devsel_n && (miss_cnt == CW'(TMO - 1));
endmodule

// File: rtl/pci_mst_beat_cnt.sv
// Holds the burst length and counts completed data phases.
module pci_mst_beat_cnt #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             adv,
  output logic [LEN_W-1:0] count,
  output logic             last,
  output logic             next_last
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= LEN_W'(1);
      count <= '0;
    end else if (load) begin
      len_q <= (len_in == '0) ? LEN_W'(1) : len_in;
      count <= '0;
    end else if (adv) begin
      count <= count + 1'b1;
    end
  end

  assign last      = ({1'b0, count} + 1'b1) == {1'b0, len_q};
  assign next_last = ({1'b0, count} + 2'd2) == {1'b0, len_q};
endmodule

// File: rtl/pci_mst_seq.sv
module pci_mst_seq
  import pci_mst_pkg::*;
#(
  parameter int DW       = 32,
  parameter int LEN_W    = 4,
  parameter int DSEL_TMO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DW-1:0]    start_addr,
  input  logic [3:0]       start_cmd,
  input  logic [3:0]       start_be_n,
  input  logic [LEN_W-1:0] start_len,
  input  logic [DW-1:0]    wdata,
  output logic [LEN_W-1:0] wr_idx,
  output logic             idle,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic [1:0]       done_status,
  output logic [LEN_W-1:0] beat_count,
  output logic             mabort_flag,
  input  logic             mabort_clr,
  output logic             req_n,
  input  logic             gnt_n,
  output logic             frame_n_o,
  output logic             frame_oe,
  output logic             irdy_n_o,
  output logic             irdy_oe,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe,
  output logic [3:0]       cbe_n_o,
  output logic             cbe_oe,
  input  logic [DW-1:0]    ad_i,
  input  logic             trdy_n,
  input  logic             devsel_n,
  input  logic             stop_n
);
  mst_state_e  st;
  mst_status_e term_q, term_code, end_code;
  logic [DW-1:0] addr_q;
  logic [3:0]    cmd_q, be_q;
  logic          is_wr;
  logic          accept, expired, retry, hit, good_hit, term_now, end_now;
  logic          last, next_last;

  assign accept   = (st == ST_IDLE) && start;
  assign retry    = (st == ST_DATA) && !stop_n && trdy_n;
  assign hit      = (st == ST_DATA) && !irdy_n_o && !trdy_n;
  assign good_hit = hit && !expired;

  pci_mst_dsel_timer #(.TMO(DSEL_TMO)) u_timer (
    .clk(clk), .rst(rst), .run(st == ST_DATA), .devsel_n(devsel_n),
    .expired(expired)
  );

  pci_mst_beat_cnt #(.LEN_W(LEN_W)) u_beats (
    .clk(clk), .rst(rst), .load(accept), .len_in(start_len), .adv(good_hit),
    .count(beat_count), .last(last), .next_last(next_last)
  );

  always_comb begin
    term_now  = 1'b0;
    term_code = STAT_OK;
    if (st == ST_DATA) begin
      if (expired) begin
        term_now  = 1'b1;
        term_code = STAT_MABORT;
      end else if (retry) begin
        term_now  = 1'b1;
        term_code = STAT_RETRY;
      end else if (hit && last) begin
        term_now  = 1'b1;
        term_code = STAT_OK;
      end
    end
    end_now  = (st == ST_DRAIN) || (term_now && frame_n_o);
    end_code = (st == ST_DRAIN) ? term_q : term_code;
  end

  assign idle = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      term_q      <= STAT_OK;
      addr_q      <= '0;
      cmd_q       <= '0;
      be_q        <= '0;
      is_wr       <= 1'b0;
      wr_idx      <= '0;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      done        <= 1'b0;
      done_status <= STAT_OK;
      mabort_flag <= 1'b0;
      req_n       <= 1'b1;
      frame_n_o   <= 1'b1;
      frame_oe    <= 1'b0;
      irdy_n_o    <= 1'b1;
      irdy_oe     <= 1'b0;
      ad_o        <= '0;
      ad_oe       <= 1'b0;
      cbe_n_o     <= '0;
      cbe_oe      <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (mabort_clr) mabort_flag <= 1'b0;

      case (st)
        ST_IDLE: if (start) begin
          addr_q <= start_addr;
          cmd_q  <= start_cmd;
          be_q   <= start_be_n;
          is_wr  <= cmd_is_write(start_cmd);
          wr_idx <= '0;
          req_n  <= 1'b0;
          st     <= ST_REQ;
        end
        ST_REQ: if (!gnt_n) begin
          req_n     <= 1'b1;
          frame_n_o <= 1'b0;
          frame_oe  <= 1'b1;
          irdy_n_o  <= 1'b1;
          irdy_oe   <= 1'b1;
          ad_o      <= addr_q;
          ad_oe     <= 1'b1;
          cbe_n_o   <= cmd_q;
          cbe_oe    <= 1'b1;
          st        <= ST_ADDR;
        end
        ST_ADDR: begin
          irdy_n_o  <= 1'b0;
          cbe_n_o   <= be_q;
          ad_oe     <= is_wr;
          ad_o      <= is_wr ? wdata : '0;
          wr_idx    <= LEN_W'(1);
          frame_n_o <= last;
          st        <= ST_DATA;
        end
        ST_DATA: begin
          if (good_hit) begin
            if (!is_wr) begin
              rd_data  <= ad_i;
              rd_valid <= 1'b1;
            end
            if (!last) begin
              if (is_wr) ad_o <= wdata;
              wr_idx <= wr_idx + 1'b1;
              if (next_last) frame_n_o <= 1'b1;
            end
          end
          if (term_now && !frame_n_o) begin
            frame_n_o <= 1'b1;
            term_q    <= term_code;
            st        <= ST_DRAIN;
          end
        end
        ST_TURN: st <= ST_IDLE;
        default: ;
      endcase

      if (end_now) begin
        st          <= ST_TURN;
        frame_n_o   <= 1'b1;
        frame_oe    <= 1'b0;
        irdy_n_o    <= 1'b1;
        irdy_oe     <= 1'b0;
        ad_oe       <= 1'b0;
        cbe_oe      <= 1'b0;
        done        <= 1'b1;
        done_status <= end_code;
        if (end_code == STAT_MABORT) mabort_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pci_mst_seq_chk.sv
module pci_mst_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       gnt_n,
  input logic       req_n,
  input logic       frame_n_o,
  input logic       frame_oe,
  input logic       irdy_n_o,
  input logic       irdy_oe,
  input logic       ad_oe,
  input logic       cbe_oe,
  input logic       trdy_n,
  input logic       rd_valid,
  input logic       done,
  input logic [1:0] done_status,
  input logic       mabort_flag
);
  a_r1_frame_after_gnt: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_n_o) |-> $past(!gnt_n) && $past(!req_n));

  a_r1_req_released: assert property (@(posedge clk) disable iff (rst)
    !frame_n_o |-> req_n);

  a_r2_irdy_follows_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_n_o) |=> !irdy_n_o);

  a_r3_read_on_handshake: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!irdy_n_o && !trdy_n));

  a_r5_turnaround_float: assert property (@(posedge clk) disable iff (rst)
    done |-> !frame_oe && !irdy_oe && !ad_oe && !cbe_oe);

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_frame_before_irdy: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_n_o) |-> !irdy_n_o);

  a_r9_flag_on_abort: assert property (@(posedge clk) disable iff (rst)
    (done && done_status == 2'd2) |-> mabort_flag);
endmodule

bind pci_mst_seq pci_mst_seq_chk u_chk (
  .clk(clk), .rst(rst), .gnt_n(gnt_n), .req_n(req_n),
  .frame_n_o(frame_n_o), .frame_oe(frame_oe), .irdy_n_o(irdy_n_o),
  .irdy_oe(irdy_oe), .ad_oe(ad_oe), .cbe_oe(cbe_oe), .trdy_n(trdy_n),
  .rd_valid(rd_valid), .done(done), .done_status(done_status),
  .mabort_flag(mabort_flag)
);

// File: tb/pci_mst_seq_tb_top.sv
`timescale 1ns/1ps
module pci_mst_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [3:0]  start_cmd = '0, start_be_n = '0, start_len = '0;
  logic [31:0] wdata;
  logic [3:0]  wr_idx, beat_count, cbe_n_o;
  logic        idle, rd_valid, done, mabort_flag, req_n;
  logic [31:0] rd_data, ad_o;
  logic [1:0]  done_status;
  logic        mabort_clr = 1'b0, gnt_n = 1'b1;
  logic        frame_n_o, frame_oe, irdy_n_o, irdy_oe, ad_oe, cbe_oe;
  logic [31:0] ad_i = '0;
  logic        trdy_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1;

  always #2 clk = ~clk;

  assign wdata = 32'hC0DE_0000 + {28'h0, wr_idx};

  pci_mst_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .start_cmd(start_cmd), .start_be_n(start_be_n), .start_len(start_len),
    .wdata(wdata), .wr_idx(wr_idx), .idle(idle), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .done_status(done_status),
    .beat_count(beat_count), .mabort_flag(mabort_flag), .mabort_clr(mabort_clr),
    .req_n(req_n), .gnt_n(gnt_n), .frame_n_o(frame_n_o), .frame_oe(frame_oe),
    .irdy_n_o(irdy_n_o), .irdy_oe(irdy_oe), .ad_o(ad_o), .ad_oe(ad_oe),
    .cbe_n_o(cbe_n_o), .cbe_oe(cbe_oe), .ad_i(ad_i), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .stop_n(stop_n)
  );

  int checks = 0, fails = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // target model, all activity on the falling edge
  int t_dsel = 1, t_wait = 0, t_retry = -1;
  int tcyc = 0, tbeat = 0, ncap = 0, nr = 0, rd_drive_err = 0;
  logic is_wr_tb = 1'b0;
  logic last_irdy = 1'b1, last_trdy = 1'b1, last_oe = 1'b0;
  logic [31:0] last_ad = '0;
  logic [31:0] cap [16];
  logic [31:0] rcap [16];

  always @(negedge clk) begin
    logic claim, stopnow, waitnow;
    if (last_oe && !last_irdy && !last_trdy) begin
      if (is_wr_tb && ncap < 16) cap[ncap] = last_ad;
      if (is_wr_tb) ncap++;
      tbeat++;
    end
    if (rd_valid && nr < 16) rcap[nr] = rd_data;
    if (rd_valid) nr++;
    if (!is_wr_tb && irdy_oe && !irdy_n_o && ad_oe) rd_drive_err++;
    if (!irdy_oe) begin
      tcyc = 0;
      tbeat = 0;
    end else if (!irdy_n_o) tcyc++;
    claim   = irdy_oe && !irdy_n_o && (tcyc >= t_dsel);
    stopnow = claim && (tbeat == t_retry);
    waitnow = (t_wait != 0) && (tcyc % 2 == 0);
    devsel_n <= !claim;
    stop_n   <= !stopnow;
    trdy_n   <= !(claim && !stopnow && !waitnow);
    ad_i     <= 32'hA000_0000 + tbeat;
    last_irdy = irdy_n_o;
    last_oe   = irdy_oe;
    last_trdy = !(claim && !stopnow && !waitnow);
    last_ad   = ad_o;
  end

  logic [1:0] got_status;
  logic [3:0] got_beats;
  logic got_done, turn_ok, idle_after;

  task automatic run_txn(input logic [31:0] a, input logic [3:0] c,
                         input logic [3:0] be, input logic [3:0] len, input int gd);
    ncap = 0; nr = 0; rd_drive_err = 0; is_wr_tb = c[0];
    @(negedge clk);
    start = 1'b1; start_addr = a; start_cmd = c; start_be_n = be; start_len = len;
    @(negedge clk);
    start = 1'b0;
    repeat (gd) @(negedge clk);
    gnt_n = 1'b0;
    got_done = 1'b0; turn_ok = 1'b0;
    for (int i = 0; i < 100 && !got_done; i++) begin
      @(negedge clk);
      if (done) begin
        got_done = 1'b1; got_status = done_status; got_beats = beat_count;
        turn_ok = !frame_oe && !irdy_oe && !ad_oe && !cbe_oe;
      end
    end
    gnt_n = 1'b1;
    @(negedge clk);
    idle_after = idle;
    chk("R5 done seen", 32'(got_done), 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 reset idle", 32'(idle), 32'd1);
    chk("R1 reset req_n", 32'(req_n), 32'd1);
    chk("R5 reset floats", 32'({frame_oe, irdy_oe, ad_oe, cbe_oe}), 32'd0);
    chk("R9 reset flag", 32'(mabort_flag), 32'd0);
  endtask

  task automatic t_single_write;
    t_dsel = 1; t_wait = 0; t_retry = -1; ncap = 0; is_wr_tb = 1'b1;
    @(negedge clk);
    start = 1'b1; start_addr = 32'h1000_0040; start_cmd = 4'h7;
    start_be_n = 4'b1100; start_len = 4'd1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 req asserted", 32'(req_n), 32'd0);
    chk("R1 no frame before grant", 32'(frame_n_o), 32'd1);
    @(negedge clk);
    chk("R1 still waiting", 32'(frame_n_o), 32'd1);
    gnt_n = 1'b0;
    @(negedge clk);
    chk("R1 frame after grant", 32'({frame_oe, frame_n_o}), 32'b10);
    chk("R1 address", ad_o, 32'h1000_0040);
    chk("R1 command", 32'(cbe_n_o), 32'h7);
    chk("R1 req released", 32'(req_n), 32'd1);
    @(negedge clk);
    chk("R2 irdy asserted", 32'(irdy_n_o), 32'd0);
    chk("R2 byte enables", 32'(cbe_n_o), 32'b1100);
    chk("R2 write word 0", ad_o, 32'hC0DE_0000);
    chk("R4 single phase frame high", 32'(frame_n_o), 32'd1);
    got_done = 1'b0;
    for (int i = 0; i < 20 && !got_done; i++) begin
      @(negedge clk);
      if (done) begin
        got_done = 1'b1; got_status = done_status; got_beats = beat_count;
      end
    end
    gnt_n = 1'b1;
    @(negedge clk);
    chk("R5 single status", 32'(got_status), 32'd0);
    chk("R5 single beats", 32'(got_beats), 32'd1);
    chk("R3 single write data", cap[0], 32'hC0DE_0000);
    chk("R5 back to idle", 32'(idle), 32'd1);
  endtask

  task automatic t_burst_write_waits;
    t_dsel = 2; t_wait = 1; t_retry = -1;
    run_txn(32'h2000_0000, 4'h7, 4'b0000, 4'd4, 0);
    chk("R5 burst write status", 32'(got_status), 32'd0);
    chk("R5 burst write beats", 32'(got_beats), 32'd4);
    chk("R5 turnaround float", 32'(turn_ok), 32'd1);
    chk("R5 idle after", 32'(idle_after), 32'd1);
    chk("R10 words captured", 32'(ncap), 32'd4);
    for (int k = 0; k < 4; k++) chk("R10 R3 write word", cap[k], 32'hC0DE_0000 + k);
  endtask

  task automatic t_burst_read;
    t_dsel = 3; t_wait = 1; t_retry = -1;
    run_txn(32'h3000_0100, 4'h6, 4'b0000, 4'd4, 1);
    chk("R5 read status", 32'(got_status), 32'd0);
    chk("R5 read beats", 32'(got_beats), 32'd4);
    chk("R3 read strobes", 32'(nr), 32'd4);
    chk("R2 read ad floats", 32'(rd_drive_err), 32'd0);
    for (int k = 0; k < 4; k++) chk("R3 read word", rcap[k], 32'hA000_0000 + k);
  endtask

  task automatic t_late_claim;
    t_dsel = 8; t_wait = 0; t_retry = -1;
    run_txn(32'h4000_0000, 4'h7, 4'b0000, 4'd2, 0);
    chk("R6 claim on 8th sample ok", 32'(got_status), 32'd0);
    chk("R6 claim on 8th sample beats", 32'(got_beats), 32'd2);
  endtask

  task automatic t_abort_burst;
    t_dsel = 100; t_wait = 0; t_retry = -1;
    run_txn(32'h5000_0000, 4'h6, 4'b0000, 4'd3, 0);
    chk("R6 abort status", 32'(got_status), 32'd2);
    chk("R6 abort beats", 32'(got_beats), 32'd0);
    chk("R8 abort floats after drain", 32'(turn_ok), 32'd1);
    chk("R9 flag set", 32'(mabort_flag), 32'd1);
    repeat (3) @(negedge clk);
    chk("R9 flag sticky", 32'(mabort_flag), 32'd1);
    mabort_clr = 1'b1;
    @(negedge clk);
    mabort_clr = 1'b0;
    chk("R9 flag cleared", 32'(mabort_flag), 32'd0);
  endtask

  task automatic t_abort_single;
    t_dsel = 100; t_wait = 0; t_retry = -1;
    run_txn(32'h5000_0004, 4'h7, 4'b0000, 4'd1, 0);
    chk("R6 single abort status", 32'(got_status), 32'd2);
    chk("R9 flag set again", 32'(mabort_flag), 32'd1);
    mabort_clr = 1'b1;
    @(negedge clk);
    mabort_clr = 1'b0;
  endtask

  task automatic t_retry_mid;
    t_dsel = 1; t_wait = 0; t_retry = 2;
    run_txn(32'h6000_0000, 4'h7, 4'b0000, 4'd4, 0);
    chk("R7 retry status", 32'(got_status), 32'd1);
    chk("R7 retry beats", 32'(got_beats), 32'd2);
    chk("R7 words before stop", 32'(ncap), 32'd2);
    chk("R8 retry floats", 32'(turn_ok), 32'd1);
    chk("R7 no abort flag", 32'(mabort_flag), 32'd0);
    t_retry = -1;
  endtask

  task automatic t_len_zero;
    t_dsel = 1; t_wait = 0; t_retry = -1;
    run_txn(32'h7000_0000, 4'h6, 4'b0000, 4'd0, 0);
    chk("R4 zero length status", 32'(got_status), 32'd0);
    chk("R4 zero length beats", 32'(got_beats), 32'd1);
    chk("R4 zero length reads", 32'(nr), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single_write();
    t_burst_write_waits();
    t_burst_read();
    t_late_claim();
    t_abort_burst();
    t_abort_single();
    t_retry_mid();
    t_len_zero();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule